// File: doc/BRIEF.md
# Predicated Vector Element Compactor

This block executes one vector permute operation: it gathers the elements of a source vector whose predicate bit is set and packs them, in rising source order, into the low end of a result vector. Every result lane above the last packed element is cleared. Elements are 32 or 64 bits wide, chosen by a size field in the instruction word. The vector length is a parameter, a multiple of 128 bits.

The predicate has one bit per byte of the vector. For each element size the block reads that element's active bit from a fixed position in the predicate. A small decoder checks the instruction word and pulls out the destination, source and predicate register numbers. Words that do not match the encoding, or that carry an unallocated size code, are flagged as illegal and give an all-zero result.

The whole result is formed in one combinational pass and captured into an output register. The caller pulses `start` for one cycle. `done` follows one cycle later, and the outputs hold until the next `start`. Because the full result is built before anything is written back, a caller may use the same register as both source and destination.

Top module: `vec_compactor`

## Requirements
- R1: An instruction word is accepted only when bits[31:24] = 8'b00000101, bits[21:16] = 6'b100001 and bits[15:13] = 3'b100. Any other word sets `illegal` and gives an all-zero `dst_vec`.
- R2: The size field bits[23:22] selects 32-bit elements (code 2) or 64-bit elements (code 3). Codes 0 and 1 set `illegal` and give an all-zero `dst_vec`.
- R3: With 32-bit elements, element i is active when predicate bit 4*i is set. All other predicate bits have no effect on the result.
- R4: With 64-bit elements, element i is active when predicate bit 8*i (bit 0 of predicate byte i) is set. All other predicate bits have no effect on the result.
- R5: Active source elements appear in destination lanes 0, 1, 2, ... in increasing source index order.
- R6: Every destination lane after the last packed element reads zero, up to the full vector length.
- R7: `done` is high in exactly the cycle after a cycle with `start` high, and low otherwise.
- R8: `dst_vec`, `illegal` and the register-number outputs keep their values until the next `start`.
- R9: For a legal word, an all-zero predicate gives an all-zero result and an all-ones predicate gives a result equal to the source.
- R10: On each `start`, `dst_reg` takes bits[4:0], `src_reg` takes bits[9:5] and `pred_reg` takes bits[12:10] of the instruction word.
- R11: After reset, `done`, `illegal`, `dst_vec` and all register-number outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to execute `insn` |
| insn | input | 32 | Instruction word |
| src_vec | input | VLEN_BITS | Source vector, element 0 in the low bits |
| pred | input | VLEN_BITS/8 | Governing predicate, one bit per vector byte |
| done | output | 1 | Result valid pulse, one cycle after `start` |
| illegal | output | 1 | The last word was not a legal encoding |
| dst_vec | output | VLEN_BITS | Compacted result |
| dst_reg | output | 5 | Destination register number |
| src_reg | output | 5 | Source register number |
| pred_reg | output | 3 | Predicate register number |

## Verification
The bench builds the block with VLEN_BITS = 256. This gives eight 32-bit lanes and four 64-bit lanes, so the lane counts differ between the two sizes. It also leaves room for every partial packing pattern, including a lone active element in the top lane that has to move to lane 0. The predicate is 32 bits wide, so random predicates set the ignored bits about half the time. Directed predicates that set only the ignored bits, for each size, show that those bits cannot make any lane active.

// File: rtl/vcompact_pkg.sv
// Package: shared constants and types for the vector element compactor.
// Assumes: the instruction encoding fields given in the brief.
package vcompact_pkg;

    // Fixed opcode fields of the accepted instruction word
    localparam logic [7:0] OPC_TOP = 8'b0000_0101;
    localparam logic [5:0] OPC_MID = 6'b10_0001;
    localparam logic [2:0] OPC_LOW = 3'b100;

    // Allocated element size codes
    typedef enum logic [1:0] {
        ESZ_WORD  = 2'd2,
        ESZ_DWORD = 2'd3
    } elem_size_e;

    // Fields extracted from one instruction word
    typedef struct packed {
        logic [4:0] rd;
        logic [4:0] rn;
        logic [2:0] pg;
        logic [1:0] size;
        logic       opc_hit;
    } insn_fields_t;

endpackage

// File: rtl/cmp_decode.sv
// Module: cmp_decode
// Splits the instruction word into its register and size fields.
// Reports whether the word is a legal compaction op and which element size it uses.
// Assumes: purely combinational; the caller registers the results.
module cmp_decode
    import vcompact_pkg::*;
(
    input  logic [31:0]  insn,
    output insn_fields_t fields,
    output logic         legal,
    output logic         wide
);

    // Field extraction and opcode match
    always_comb begin
        fields.rd      = insn[4:0];
        fields.rn      = insn[9:5];
        fields.pg      = insn[12:10];
        fields.size    = insn[23:22];
        fields.opc_hit = (insn[31:24] == OPC_TOP) &&
                         (insn[21:16] == OPC_MID) &&
                         (insn[15:13] == OPC_LOW);
    end

    // Legality: only the two allocated size codes are accepted
    always_comb begin
        legal = fields.opc_hit &&
                ((fields.size == ESZ_WORD) || (fields.size == ESZ_DWORD));
        wide  = (fields.size == ESZ_DWORD);
    end

endmodule

// File: rtl/cmp_lane_mask.sv
// Module: cmp_lane_mask
// Picks the per-element active bits out of the byte-granular predicate,
// once for 32-bit lanes (bit 4*i) and once for 64-bit lanes (bit 8*i).
// Assumes: VLEN_BITS is a multiple of 128.
module cmp_lane_mask #(
    parameter int VLEN_BITS = 256
) (
    input  logic [VLEN_BITS/8-1:0]  pred,
    output logic [VLEN_BITS/32-1:0] act_w,
    output logic [VLEN_BITS/64-1:0] act_d
);

    localparam int NW = VLEN_BITS / 32;
    localparam int ND = VLEN_BITS / 64;

    // Bits that no element size reads; folded so they count as consumed
    logic unused_pred_bits;
    assign unused_pred_bits = ^pred;

    // 32-bit lanes: one active bit per four predicate bits
    for (genvar i = 0; i < NW; i++) begin : g_word
        assign act_w[i] = pred[4*i];
    end

    // 64-bit lanes: one active bit per predicate byte
    for (genvar i = 0; i < ND; i++) begin : g_dword
        assign act_d[i] = pred[8*i];
    end

endmodule

// File: rtl/cmp_pack_net.sv
// Module: cmp_pack_net
// Packs the active lanes of a vector into the low lanes, keeping their order,
// and zeroes the rest. Each active lane's target is the count of active
// lanes below it (a prefix count).
// Assumes: combinational; N lanes of EW bits, lane 0 in the low bits.
module cmp_pack_net #(
    parameter int EW = 32,
    parameter int N  = 8
) (
    input  logic [N*EW-1:0] src,
    input  logic [N-1:0]    act,
    output logic [N*EW-1:0] dense_o
);

    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] pos [N];

    // Prefix count of active lanes strictly below each lane
    always_comb begin
        pos[0] = '0;
        for (int i = 1; i < N; i++) begin
            pos[i] = pos[i-1] + CW'(act[i-1]);
        end
    end

    // Each output lane ORs in the single source lane whose target it is
    for (genvar k = 0; k < N; k++) begin : g_out
        logic [EW-1:0] acc;
        always_comb begin
            acc = '0;
            for (int i = k; i < N; i++) begin
                if (act[i] && (pos[i] == CW'(k))) begin
                    acc = acc | src[i*EW +: EW];
                end
            end
        end
        assign dense_o[k*EW +: EW] = acc;
    end

endmodule

// File: rtl/vec_compactor.sv
// Module: vec_compactor (top)
// Executes one compaction per start pulse: decodes the word, selects the
// active lanes for the chosen element size, packs them and registers the
// full result with done one cycle later. Outputs hold until the next start.
// Assumes: VLEN_BITS is a multiple of 128 in 128..2048; start is one cycle wide.
module vec_compactor
    import vcompact_pkg::*;
#(
    parameter int VLEN_BITS = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [31:0]            insn,
    input  logic [VLEN_BITS-1:0]   src_vec,
    input  logic [VLEN_BITS/8-1:0] pred,
    output logic                   done,
    output logic                   illegal,
    output logic [VLEN_BITS-1:0]   dst_vec,
    output logic [4:0]             dst_reg,
    output logic [4:0]             src_reg,
    output logic [2:0]             pred_reg
);

    localparam int NW = VLEN_BITS / 32;
    localparam int ND = VLEN_BITS / 64;

    insn_fields_t           fields;
    logic                   legal;
    logic                   wide;
    logic [NW-1:0]          act_w;
    logic [ND-1:0]          act_d;
    logic [VLEN_BITS-1:0]   dense_w;
    logic [VLEN_BITS-1:0]   dense_d;
    logic [VLEN_BITS-1:0]   next_vec;

    cmp_decode u_dec (
        .insn   (insn),
        .fields (fields),
        .legal  (legal),
        .wide   (wide)
    );

    cmp_lane_mask #(.VLEN_BITS(VLEN_BITS)) u_mask (
        .pred  (pred),
        .act_w (act_w),
        .act_d (act_d)
    );

    cmp_pack_net #(.EW(32), .N(NW)) u_pack_w (
        .src     (src_vec),
        .act     (act_w),
        .dense_o (dense_w)
    );

    cmp_pack_net #(.EW(64), .N(ND)) u_pack_d (
        .src     (src_vec),
        .act     (act_d),
        .dense_o (dense_d)
    );

    // Result select: packed vector of the chosen size, zero when illegal
    always_comb begin
        if (!legal) begin
            next_vec = '0;
        end else if (wide) begin
            next_vec = dense_d;
        end else begin
            next_vec = dense_w;
        end
    end

    // Done pulse follows start by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= start;
        end
    end

    // Capture the result and fields on start, hold them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_vec  <= '0;
            illegal  <= 1'b0;
            dst_reg  <= '0;
            src_reg  <= '0;
            pred_reg <= '0;
        end else if (start) begin
            dst_vec  <= next_vec;
            illegal  <= !legal;
            dst_reg  <= fields.rd;
            src_reg  <= fields.rn;
            pred_reg <= fields.pg;
        end
    end

endmodule

// File: rtl/vec_compactor_chk.sv
// Module: vec_compactor_chk
// Timing and port-level properties of the compactor, bound to the top module.
// Assumes: the same VLEN_BITS as the bound instance.
module vec_compactor_chk #(
    parameter int VLEN_BITS = 256
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic [31:0]            insn,
    input logic [VLEN_BITS-1:0]   src_vec,
    input logic [VLEN_BITS/8-1:0] pred,
    input logic                   done,
    input logic                   illegal,
    input logic [VLEN_BITS-1:0]   dst_vec,
    input logic [4:0]             dst_reg,
    input logic [4:0]             src_reg,
    input logic [2:0]             pred_reg
);

    // Independent legality check from the encoding in the brief
    function automatic logic word_ok(input logic [31:0] w);
        return (w[31:24] == 8'h05) && (w[21:16] == 6'h21) &&
               (w[15:13] == 3'b100) && w[23];
    endfunction

    // R7
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R7
    done_only_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(dst_vec) && $stable(illegal) && $stable(dst_reg)));

    // R2
    bad_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !word_ok(insn)) |=> (illegal && (dst_vec == '0)));

    // R9
    empty_pred_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && word_ok(insn) && (pred == '0)) |=> (!illegal && (dst_vec == '0)));

    // R9
    full_pred_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && word_ok(insn) && (&pred)) |=> (dst_vec == $past(src_vec)));

    // R10
    field_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((dst_reg == $past(insn[4:0])) && (src_reg == $past(insn[9:5])) &&
                   (pred_reg == $past(insn[12:10]))));

endmodule

bind vec_compactor vec_compactor_chk #(.VLEN_BITS(VLEN_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .insn     (insn),
    .src_vec  (src_vec),
    .pred     (pred),
    .done     (done),
    .illegal  (illegal),
    .dst_vec  (dst_vec),
    .dst_reg  (dst_reg),
    .src_reg  (src_reg),
    .pred_reg (pred_reg)
);

// File: tb/vec_compactor_test.sv
module vec_compactor_test;

    localparam int CLK_PERIOD = 10;
    localparam int VLEN = 256;
    localparam int PW = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [31:0]     insn = '0;
    logic [VLEN-1:0] src_vec = '0;
    logic [PW-1:0]   pred = '0;
    logic            done;
    logic            illegal;
    logic [VLEN-1:0] dst_vec;
    logic [4:0]      dst_reg;
    logic [4:0]      src_reg;
    logic [2:0]      pred_reg;

    int n_tests = 0;
    int n_fail = 0;

    vec_compactor #(.VLEN_BITS(VLEN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
        .src_vec(src_vec), .pred(pred), .done(done), .illegal(illegal),
        .dst_vec(dst_vec), .dst_reg(dst_reg), .src_reg(src_reg), .pred_reg(pred_reg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [2:0] pg,
                                       input logic [4:0] rn, input logic [4:0] rd);
        return {8'h05, sz, 6'h21, 3'b100, pg, rn, rd};
    endfunction

    function automatic logic [VLEN-1:0] rand_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Sequential reference: walk source lanes, append the active ones, rest zero
    function automatic logic [VLEN-1:0] ref_compact(input logic [31:0] w,
                                                    input logic [VLEN-1:0] s,
                                                    input logic [PW-1:0] p);
        logic [VLEN-1:0] r = '0;
        int j = 0;
        if (!((w[31:24] == 8'h05) && (w[21:16] == 6'h21) && (w[15:13] == 3'b100) && w[23]))
            return '0;
        if (w[22]) begin
            for (int i = 0; i < VLEN/64; i++)
                if (p[8*i]) begin r[j*64 +: 64] = s[i*64 +: 64]; j++; end
        end else begin
            for (int i = 0; i < VLEN/32; i++)
                if (p[4*i]) begin r[j*32 +: 32] = s[i*32 +: 32]; j++; end
        end
        return r;
    endfunction

    // Issue one operation and check every output in the cycle after start
    task automatic issue(input string req, input logic [31:0] w,
                         input logic [VLEN-1:0] s, input logic [PW-1:0] p);
        logic exp_ill;
        exp_ill = !((w[31:24] == 8'h05) && (w[21:16] == 6'h21) &&
                    (w[15:13] == 3'b100) && w[23]);
        @(negedge clk);
        insn = w; src_vec = s; pred = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R7 done"}, VLEN'(done), VLEN'(1'b1));
        chk({req, " R1 R2 illegal"}, VLEN'(illegal), VLEN'(exp_ill));
        chk({req, " R5 R6 result"}, dst_vec, ref_compact(w, s, p));
        chk({req, " R10 fields"}, VLEN'({dst_reg, src_reg, pred_reg}),
            VLEN'({w[4:0], w[9:5], w[12:10]}));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] v;
        logic [VLEN-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset", {dst_vec[VLEN-1:15], done, illegal, dst_reg, src_reg, pred_reg}, '0);
        rst_n = 1'b1;

        v = rand_vec();
        // R9: empty and full predicates, both sizes
        issue("R9 empty w", mk(2'd2, 3'd1, 5'd2, 5'd3), v, '0);
        chk("R9 empty w zero", dst_vec, '0);
        issue("R9 empty d", mk(2'd3, 3'd1, 5'd2, 5'd3), v, '0);
        issue("R9 full w", mk(2'd2, 3'd7, 5'd31, 5'd0), v, '1);
        chk("R9 full w copy", dst_vec, v);
        issue("R9 full d", mk(2'd3, 3'd0, 5'd0, 5'd31), v, '1);
        chk("R9 full d copy", dst_vec, v);
        // R3: only ignored bits set for 32-bit lanes
        issue("R3 ignored", mk(2'd2, 3'd2, 5'd4, 5'd4), v, 32'hEEEE_EEEE);
        chk("R3 ignored zero", dst_vec, '0);
        // R4: only ignored bits set for 64-bit lanes, then only used bits
        issue("R4 ignored", mk(2'd3, 3'd2, 5'd4, 5'd4), v, 32'hFEFE_FEFE);
        chk("R4 ignored zero", dst_vec, '0);
        issue("R4 used", mk(2'd3, 3'd2, 5'd4, 5'd4), v, 32'h0101_0101);
        chk("R4 used copy", dst_vec, v);
        // R5 R6: lone top element moves to lane 0
        issue("R5 top w", mk(2'd2, 3'd5, 5'd6, 5'd7), v, 32'h1000_0000);
        chk("R6 top w", dst_vec, VLEN'(v[VLEN-32 +: 32]));
        issue("R5 top d", mk(2'd3, 3'd5, 5'd6, 5'd7), v, 32'h0100_0000);
        chk("R6 top d", dst_vec, VLEN'(v[VLEN-64 +: 64]));
        // R2: unallocated size codes
        issue("R2 size0", mk(2'd0, 3'd1, 5'd1, 5'd1), v, '1);
        issue("R2 size1", mk(2'd1, 3'd1, 5'd1, 5'd1), v, '1);
        // R1: broken opcode fields
        issue("R1 top", mk(2'd2, 3'd1, 5'd1, 5'd1) ^ 32'h0100_0000, v, '1);
        issue("R1 mid", mk(2'd3, 3'd1, 5'd1, 5'd1) ^ 32'h0001_0000, v, '1);
        issue("R1 low", mk(2'd3, 3'd1, 5'd1, 5'd1) ^ 32'h0000_2000, v, '1);

        // R8: outputs hold while start is low and inputs change
        issue("R8 setup", mk(2'd2, 3'd3, 5'd9, 5'd10), v, 32'h1234_5671);
        held = dst_vec;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            insn = $urandom; src_vec = rand_vec(); pred = $urandom;
            chk("R8 hold", dst_vec, held);
            chk("R7 no done", VLEN'(done), '0);
        end

        // Random operations, both sizes, occasional bad words
        for (int k = 0; k < 120; k++) begin
            logic [31:0] w;
            w = mk({1'b1, 1'(k & 1)}, 3'($urandom), 5'($urandom), 5'($urandom));
            if (($urandom % 10) == 0) w[23:22] = 2'($urandom);
            issue("R3 R4 R5 R6 random", w, rand_vec(), PW'($urandom));
        end

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule